// File: doc/BRIEF.md
# Three-Wire Serial Register Bus Master

This block is the host side of a small serial bus that reads and writes 16-bit registers in peripheral devices. The bus has three wires: an active-low select, a bus clock and one bidirectional data line. The data line is modelled here as three separate signals: an output, an output enable and an input. The host presents a 3-bit device address, a 5-bit register address, a read flag and, for writes, a 16-bit word. It then pulses `start`. The block drives select low and shifts out a fixed 25-bit frame. On a read, it turns the data line around and shifts the returned word in. It then raises select, gives one trailing clock pulse and signals completion with a one-cycle `done`.

The parameter `HALF_CYC` sets how many system clocks each bus-clock phase lasts, low or high. It must be at least 2 so that the read turnaround falls inside the clock-high phase. Every bit costs two phases, and the end-of-frame sequence adds three more. A transfer therefore lasts exactly 53 phases.

Top module: `sbus_master`

## Requirements
- R1: After a synchronous reset, and whenever no transfer is running, `bus_sel` is 1, `bus_clk` is 0, `bus_oe` is 0, `busy` is 0 and `done` is 0. A reset asserted mid-transfer returns to this state after one clock edge.
- R2: `start` is accepted only while `busy` is 0. A `start` pulse during a transfer does not change the frame on the wires, does not change the captured data and does not begin a second transfer.
- R3: With `bus_sel` low, the first 9 rising bus-clock edges carry the device address (3 bits, MSB first), then the read flag (1 = read, 0 = write), then the register address (5 bits, MSB first).
- R4: On a write, 16 more rising edges carry `wr_data` MSB first, so there are 25 rising edges while select is low. `bus_oe` is 1 at every one of them.
- R5: Each bus-clock high phase lasts `HALF_CYC` system clocks. While the clock is high and the line is driven, `bus_dout` does not change.
- R6: On a read, `bus_oe` falls one system clock after the 9th rising edge, while `bus_clk` is still high. It stays 0 for the 16 data bits.
- R7: On a read, `bus_din` is sampled at each of the 16 following rising edges, MSB first. The assembled word is on `rd_data` when `done` is 1.
- R8: After the last frame bit, `bus_sel` rises while `bus_clk` is low. Exactly one further clock pulse, high then low, follows with select high before `done`.
- R9: `done` is a one-cycle pulse and `busy` is 0 in that cycle. `done` is observed 53×`HALF_CYC` cycles after the cycle in which `busy` first reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a transfer (accepted only when idle) |
| rd_req | input | 1 | 1 = read, 0 = write |
| dev_addr | input | 3 | Target device address |
| reg_addr | input | 5 | Target register address |
| wr_data | input | 16 | Word to write |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Word returned by a read |
| bus_sel | output | 1 | Bus select, low during a frame |
| bus_clk | output | 1 | Bus clock |
| bus_dout | output | 1 | Data line output value |
| bus_oe | output | 1 | Data line output enable |
| bus_din | input | 1 | Data line input value |

## Verification
A wrong bit counter or a bad shift register shows up at the ports as a misplaced or corrupted bit in the frame the bench records at each rising edge, within one bus-clock period of the fault. The other errors appear within the same transfer. A phase counter that runs long changes the high-phase width and the total latency. A stuck direction flag is seen at the 9th rising edge of a read, where the bench expects the line released before the clock falls. A faulty end sequence changes the count of clock pulses with select high, or lets `done` appear early or last longer than one cycle.

// File: rtl/sbus_pkg.sv
`timescale 1ns/1ps
package sbus_pkg;
  localparam int DEV_W = 3;
  localparam int REG_W = 5;
  localparam int DAT_W = 16;
  localparam int HDR_W = DEV_W + 1 + REG_W;
  localparam int FRM_W = HDR_W + DAT_W;
  localparam int IDX_W = $clog2(FRM_W + 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_LO, ST_HI, ST_TSEL, ST_THI, ST_TLO
  } seq_st_t;

  // Frame layout: device, read flag, register, data (first sent on the left)
  function automatic logic [FRM_W-1:0] pack_frame(
    input logic [DEV_W-1:0] dev, input logic rd,
    input logic [REG_W-1:0] regad, input logic [DAT_W-1:0] wdata);
    return {dev, rd, regad, rd ? {DAT_W{1'b0}} : wdata};
  endfunction

  // Number of bus-clock phases in one transfer: two per bit plus three at the end
  function automatic int unsigned xfer_phases();
    return 2 * FRM_W + 3;
  endfunction
endpackage

// File: rtl/sbus_phase_tick.sv
`timescale 1ns/1ps
module sbus_phase_tick #(
  parameter int HALF_CYC = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

  logic [CW-1:0] cnt;

  assign tick = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end

  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);
endmodule

// File: rtl/sbus_shift_tx.sv
`timescale 1ns/1ps
module sbus_shift_tx #(
  parameter int W = 25
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] frame,
  input  logic         shift,
  output logic         msb
);
  logic [W-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst)        sr <= '0;
    else if (load)  sr <= frame;
    else if (shift) sr <= {sr[W-2:0], 1'b0};
  end

  assign msb = sr[W-1];
endmodule

// File: rtl/sbus_shift_rx.sv
`timescale 1ns/1ps
module sbus_shift_rx #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         cap,
  input  logic         bit_in,
  output logic [W-1:0] word
);
  always_ff @(posedge clk) begin
    if (rst || clr) word <= '0;
    else if (cap)   word <= {word[W-2:0], bit_in};
  end
endmodule

// File: rtl/sbus_seq.sv
`timescale 1ns/1ps
module sbus_seq
  import sbus_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             rd_req,
  input  logic             tick,
  output seq_st_t          state,
  output logic             accept,
  output logic             shift_evt,
  output logic             cap_evt,
  output logic             oe,
  output logic             done
);
  localparam logic [IDX_W-1:0] LAST_BIT = IDX_W'(FRM_W - 1);
  localparam logic [IDX_W-1:0] TURN_BIT = IDX_W'(HDR_W - 1);
  localparam logic [IDX_W-1:0] FIRST_RX = IDX_W'(HDR_W);

  seq_st_t          nxt;
  logic [IDX_W-1:0] idx;
  logic             rd_q;
  logic             rise_evt;

  assign accept    = start && (state == ST_IDLE);
  assign rise_evt  = (state == ST_LO) && tick;
  assign shift_evt = (state == ST_HI) && tick;
  assign cap_evt   = rise_evt && rd_q && (idx >= FIRST_RX);

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE: if (start) nxt = ST_LO;
      ST_LO:   if (tick)  nxt = ST_HI;
      ST_HI:   if (tick)  nxt = (idx == LAST_BIT) ? ST_TSEL : ST_LO;
      ST_TSEL: if (tick)  nxt = ST_THI;
      ST_THI:  if (tick)  nxt = ST_TLO;
      ST_TLO:  if (tick)  nxt = ST_IDLE;
      default:            nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      idx   <= '0;
      rd_q  <= 1'b0;
      oe    <= 1'b0;
      done  <= 1'b0;
    end else begin
      state <= nxt;
      done  <= (state == ST_TLO) && tick;
      if (accept) begin
        idx  <= '0;
        rd_q <= rd_req;
        oe   <= 1'b1;
      end else begin
        if (shift_evt) idx <= idx + 1'b1;
        // Read turnaround: release one cycle into the high phase of the last header bit
        if ((state == ST_HI) && rd_q && (idx == TURN_BIT)) oe <= 1'b0;
        if (shift_evt && (idx == LAST_BIT))                 oe <= 1'b0;
      end
    end
  end

  p_turn_in_hi_r6: assert property (@(posedge clk) disable iff (rst)
    ($fell(oe) && rd_q && (state != ST_TSEL)) |-> (state == ST_HI && idx == TURN_BIT));
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_no_restart_r2: assert property (@(posedge clk) disable iff (rst)
    (start && state != ST_IDLE) |=> $stable(rd_q));
endmodule

// File: rtl/sbus_master.sv
`timescale 1ns/1ps
module sbus_master
  import sbus_pkg::*;
#(
  parameter int HALF_CYC = 3
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic        rd_req,
  input  logic [2:0]  dev_addr,
  input  logic [4:0]  reg_addr,
  input  logic [15:0] wr_data,
  output logic        busy,
  output logic        done,
  output logic [15:0] rd_data,
  output logic        bus_sel,
  output logic        bus_clk,
  output logic        bus_dout,
  output logic        bus_oe,
  input  logic        bus_din
);
  seq_st_t state;
  logic    tick, accept, shift_evt, cap_evt, oe_q, tx_msb;

  sbus_phase_tick #(.HALF_CYC(HALF_CYC)) u_tick (
    .clk(clk), .rst(rst), .run(state != ST_IDLE), .tick(tick)
  );

  sbus_seq u_seq (
    .clk(clk), .rst(rst), .start(start), .rd_req(rd_req), .tick(tick),
    .state(state), .accept(accept), .shift_evt(shift_evt),
    .cap_evt(cap_evt), .oe(oe_q), .done(done)
  );

  sbus_shift_tx #(.W(FRM_W)) u_tx (
    .clk(clk), .rst(rst), .load(accept),
    .frame(pack_frame(dev_addr, rd_req, reg_addr, wr_data)),
    .shift(shift_evt), .msb(tx_msb)
  );

  sbus_shift_rx #(.W(DAT_W)) u_rx (
    .clk(clk), .rst(rst), .clr(accept), .cap(cap_evt),
    .bit_in(bus_din), .word(rd_data)
  );

  assign busy     = (state != ST_IDLE);
  assign bus_sel  = !((state == ST_LO) || (state == ST_HI));
  assign bus_clk  = (state == ST_HI) || (state == ST_THI);
  assign bus_oe   = oe_q;
  assign bus_dout = oe_q & tx_msb;

  p_idle_lines_r1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (bus_sel && !bus_clk && !bus_oe));
  p_dout_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (bus_clk && $past(bus_clk) && bus_oe && $past(bus_oe)) |-> $stable(bus_dout));
  p_sel_rise_low_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_sel) |-> !bus_clk);
  p_done_idle_r9: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && bus_sel));
endmodule

// File: tb/sbus_master_test.sv
`timescale 1ns/1ps
module sbus_master_test;
  localparam int HALF = 3;
  localparam int NV = 6;
  // {rd, dev[2:0], reg[4:0], data[15:0]}; data is write word or slave reply
  localparam logic [24:0] VEC [NV] = '{
    {1'b0, 3'd5, 5'h1A, 16'hA5C3},
    {1'b1, 3'd2, 5'h03, 16'h8001},
    {1'b0, 3'd7, 5'h1F, 16'hFFFF},
    {1'b1, 3'd0, 5'h00, 16'h0000},
    {1'b1, 3'd7, 5'h1F, 16'hFFFF},
    {1'b0, 3'd1, 5'h10, 16'h0001}
  };

  logic clk = 0, rst = 1, start = 0, rd_req = 0, bus_din = 0;
  logic [2:0] dev_addr = 0;
  logic [4:0] reg_addr = 0;
  logic [15:0] wr_data = 0;
  logic busy, done, bus_sel, bus_clk, bus_dout, bus_oe;
  logic [15:0] rd_data;

  sbus_master #(.HALF_CYC(HALF)) uut (
    .clk(clk), .rst(rst), .start(start), .rd_req(rd_req),
    .dev_addr(dev_addr), .reg_addr(reg_addr), .wr_data(wr_data),
    .busy(busy), .done(done), .rd_data(rd_data), .bus_sel(bus_sel),
    .bus_clk(bus_clk), .bus_dout(bus_dout), .bus_oe(bus_oe), .bus_din(bus_din)
  );

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // Bus monitor and slave model
  logic cur_rd = 0;
  logic [15:0] slave_word = 0;
  int rises, tail, t0, bad_oe, bad_hold, bad_width, hi_len;
  logic [24:0] capbits;
  logic prev_clk, prev_busy, prev_oe, prev_dout, last_hi_oe;

  always @(negedge clk) begin
    if (rst) begin
      rises <= 0; tail <= 0; t0 <= 0; bad_oe <= 0; bad_hold <= 0;
      bad_width <= 0; hi_len <= 0; capbits <= '0; bus_din <= 1'b0;
    end else if (busy && !prev_busy) begin
      rises <= 0; tail <= 0; t0 <= cyc; bad_oe <= 0; bad_hold <= 0;
      bad_width <= 0; hi_len <= 0; capbits <= '0;
    end else begin
      hi_len <= bus_clk ? hi_len + 1 : 0;
      if (bus_clk) last_hi_oe <= bus_oe;
      if (bus_clk && !prev_clk) begin
        if (!bus_sel) begin
          rises <= rises + 1;
          capbits <= {capbits[23:0], bus_dout};
          if (bus_oe != (!cur_rd || rises < 9)) bad_oe <= bad_oe + 1;
        end else tail <= tail + 1;
      end
      if (!bus_clk && prev_clk) begin
        if (hi_len != HALF) bad_width <= bad_width + 1;
        if (cur_rd && rises == 9 && last_hi_oe) bad_oe <= bad_oe + 1;
        if (cur_rd && !bus_sel && rises >= 9 && rises < 25)
          bus_din <= slave_word[24 - rises];
      end
      if (bus_clk && prev_clk && bus_oe && prev_oe && bus_dout != prev_dout)
        bad_hold <= bad_hold + 1;
    end
    prev_clk <= bus_clk; prev_busy <= busy; prev_oe <= bus_oe; prev_dout <= bus_dout;
  end

  task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_xfer(input logic [24:0] v, input logic inject);
    int waited;
    cur_rd = v[24];
    slave_word = v[15:0];
    @(negedge clk); #1;
    rd_req = v[24]; dev_addr = v[23:21]; reg_addr = v[20:16]; wr_data = v[15:0];
    start = 1;
    @(negedge clk); #1;
    start = 0;
    if (inject) begin
      repeat (40) @(negedge clk);
      #1;
      rd_req = ~v[24]; dev_addr = ~v[23:21]; reg_addr = ~v[20:16]; wr_data = ~v[15:0];
      start = 1;
      @(negedge clk); #1;
      start = 0;
    end
    waited = 0;
    do begin
      @(negedge clk);
      waited++;
    end while (!done && waited < 1000);
    chk(done, "R9 done timeout", 32'(waited), 32'(53 * HALF));
    chk(cyc - t0 == 53 * HALF, "R9 latency", 32'(cyc - t0), 32'(53 * HALF));
    chk(!busy, "R9 busy low with done", 32'(busy), 0);
    chk(rises == 25, "R4 rising edges with select low", 32'(rises), 25);
    chk(capbits[24:16] == {v[23:21], v[24], v[20:16]}, "R3 header bits",
        32'(capbits[24:16]), 32'({v[23:21], v[24], v[20:16]}));
    if (!v[24])
      chk(capbits[15:0] == v[15:0], "R4 write data", 32'(capbits[15:0]), 32'(v[15:0]));
    else
      chk(rd_data == v[15:0], "R7 read data", 32'(rd_data), 32'(v[15:0]));
    chk(bad_oe == 0, v[24] ? "R6 turnaround" : "R4 output enable", 32'(bad_oe), 0);
    chk(bad_hold == 0 && bad_width == 0, "R5 phase width / data hold",
        32'(bad_hold + bad_width), 0);
    chk(tail == 1 && bus_sel && !bus_clk, "R8 trailing pulse", 32'(tail), 1);
    @(negedge clk);
    chk(!done, "R9 done one cycle", 32'(done), 0);
    if (inject) begin
      repeat (4) @(negedge clk);
      chk(!busy && bus_sel, "R2 start while busy ignored", 32'(busy), 0);
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rst = 0;
    @(negedge clk);
    chk(bus_sel && !bus_clk && !bus_oe && !busy && !done, "R1 reset state",
        {27'd0, bus_sel, bus_clk, bus_oe, busy, done}, 32'h10);
    for (int i = 0; i < NV; i++) run_xfer(VEC[i], 1'b0);
    // R2: start pulse during a write and during a read
    run_xfer({1'b0, 3'd6, 5'h0B, 16'h3C5A}, 1'b1);
    run_xfer({1'b1, 3'd3, 5'h15, 16'hC3A5}, 1'b1);
    // R1: reset mid-transfer
    @(negedge clk); #1;
    rd_req = 0; start = 1;
    @(negedge clk); #1;
    start = 0;
    repeat (20) @(negedge clk);
    #1 rst = 1;
    @(negedge clk); #1;
    rst = 0;
    chk(bus_sel && !bus_clk && !bus_oe && !busy, "R1 reset mid-transfer",
        {28'd0, bus_sel, bus_clk, bus_oe, busy}, 32'h8);
    repeat (5) @(negedge clk);
    chk(!busy && !done, "R1 stays idle after reset", 32'(busy), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule